// File: doc/BRIEF.md
# Vectored Interrupt Controller with Banked Sources

This block gathers 96 level-sensitive interrupt sources, arranged as three banks of 32, and presents them to a processor as two request lines: a normal request and a fast request. Each source that is high while its enable bit is set is latched into a pending bit. The pending bit stays set until software clears it. A per-bank mask, a per-bank route-select and a 2-bit priority for every source decide whether a pending source is delivered, and on which line.

Software reaches the controller through a plain 32-bit register port: an address, a write strobe with write data, and a read strobe. Read data is registered and appears one cycle after the read strobe. A vector register names the highest-priority deliverable source on the normal line, so a handler can dispatch without scanning the pending words. Source 0 doubles as the "nothing to do" code and is never delivered.

Top module: `vec_intc`

## Requirements
- R1: Source s maps to bank s>>5, bit s&31. When source s is high and its enable bit is 1, its pending bit is set. The enable register of bank b is at 0x40+4b. The pending bit stays set after the source falls.
- R2: The normal pending register of bank b is at 0x10+4b and the fast pending register is at 0x20+4b. Writing 1 to a bit clears that pending bit, and writing 0 leaves it as it was. A source that is still high and enabled sets its bit again in the same cycle as the clear.
- R3: The mask register of bank b is at 0x50+4b. A mask bit of 1 keeps its source off both request lines and out of the vector. A mask bit of 0 lets it through.
- R4: An enable bit of 0 stops capture of new events. It also withholds a bit that is already pending from both request lines and from the vector. The pending bit itself is kept.
- R5: The select register of bank b is at 0x30+4b. A select bit of 1 routes its source to the fast pending register and to fiq_o. A select bit of 0 routes it to the normal pending register and to irq_o. A pending clear only acts on bits routed to the register that is written. The vector covers normally routed sources only.
- R6: Reading 0x00 returns the winning source number shifted left by 2. It returns 0 when nothing is deliverable. irq_o is 1 exactly when the vector is nonzero. Source 0 is never delivered on either line.
- R7: Source s has a 2-bit priority at 0x80+4*(s>>4), bits 2*(s&15)+1 down to 2*(s&15). The value 3 is the highest. Among deliverable sources the highest value wins, and a tie goes to the lowest source number.
- R8: Registers 0x04, 0x08 and 0x0c, the response registers at 0x60+4b, and the select, enable, mask and priority registers read back exactly what was last written.
- R9: Offsets that are not defined or not word-aligned read as 0, and writes to them change no state. Read data is captured on the edge that samples bus_rd. bus_rdata holds its value when no read is made.
- R10: After reset every register, every pending bit, bus_rdata, irq_o and fiq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_i | input | 96 | Level-sensitive interrupt sources |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Faults in the pending, enable, mask or select state show up on irq_o and fiq_o in the same cycle, because both lines are combinational from those registers. The same faults show up in the vector on the next read. A wrong priority comparison or wrong tie-breaking shows up only when two sources with different or equal fields are pending together, so the bench pairs sources across priority words and sweeps all sixteen field combinations. A faulty bank/bit mapping is caught by walking a single pending source through every number from 1 to 95 and reading the vector each time.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int BANKS     = 3;
  localparam int BANK_W    = 32;
  localparam int NSRC      = BANKS * BANK_W;
  localparam int PRIO_W    = 2;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int PER_PRIO  = DATA_W / PRIO_W;
  localparam int PRIO_REGS = (NSRC + PER_PRIO - 1) / PER_PRIO;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int SELIDX_W  = 3;

  typedef enum logic [3:0] {
    K_NONE, K_VEC, K_BASE, K_PROT, K_NMI, K_IPEND, K_FPEND,
    K_SEL, K_EN, K_MASK, K_RESP, K_PRIO
  } regKind_e;

  typedef struct packed {
    logic                wr;
    logic                rd;
    regKind_e            kind;
    logic [SELIDX_W-1:0] idx;
  } busStrobe_t;
endpackage

// File: rtl/vec_intc_ctrl.sv
module vec_intc_ctrl
  import vec_intc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output busStrobe_t        strb
);
  logic bankOk;
  logic prioOk;

  assign bankOk = int'(busAddr[3:2]) < BANKS;
  assign prioOk = int'(busAddr[4:2]) < PRIO_REGS;

  always_comb begin
    strb.wr   = busWr;
    strb.rd   = busRd;
    strb.kind = K_NONE;
    strb.idx  = {1'b0, busAddr[3:2]};
    if (busAddr[1:0] == 2'b00) begin
      unique case (busAddr[7:4])
        4'h0: begin
          unique case (busAddr[3:2])
            2'd0: strb.kind = K_VEC;
            2'd1: strb.kind = K_BASE;
            2'd2: strb.kind = K_PROT;
            default: strb.kind = K_NMI;
          endcase
        end
        4'h1: if (bankOk) strb.kind = K_IPEND;
        4'h2: if (bankOk) strb.kind = K_FPEND;
        4'h3: if (bankOk) strb.kind = K_SEL;
        4'h4: if (bankOk) strb.kind = K_EN;
        4'h5: if (bankOk) strb.kind = K_MASK;
        4'h6: if (bankOk) strb.kind = K_RESP;
        4'h8, 4'h9: begin
          if (prioOk) begin
            strb.kind = K_PRIO;
            strb.idx  = busAddr[4:2];
          end
        end
        default: strb.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb
  import vec_intc_pkg::*;
(
  input  logic [NSRC-1:0]        elig,
  input  logic [PRIO_W*NSRC-1:0] prioFlat,
  output logic                   winValid,
  output logic [IDX_W-1:0]       winIdx
);
  logic [PRIO_W-1:0] bestPrio;

  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    // ascending scan, strict compare: equal fields keep the lower number
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!winValid || prioFlat[PRIO_W*i +: PRIO_W] > bestPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        bestPrio = prioFlat[PRIO_W*i +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
  import vec_intc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  busStrobe_t             strb,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [NSRC-1:0]        src,
  input  logic                   winValid,
  input  logic [IDX_W-1:0]       winIdx,
  output logic [DATA_W-1:0]      rdata,
  output logic [NSRC-1:0]        eligIrq,
  output logic [NSRC-1:0]        eligFiq,
  output logic [PRIO_W*NSRC-1:0] prioFlat,
  output logic                   irqOut,
  output logic                   fiqOut
);
  logic [DATA_W-1:0] baseQ, protQ, nmiQ;
  logic [BANKS-1:0][BANK_W-1:0] selQ, enQ, maskQ, respQ, clrB;
  logic [PRIO_REGS-1:0][DATA_W-1:0] prioQ;
  logic [NSRC-1:0] pendQ, pendD, selF, enF, maskF, clrF, eligF;
  logic [PRIO_REGS*DATA_W-1:0] prioAll;
  logic [DATA_W-1:0] rdNext;
  logic doWr;

  assign doWr    = strb.wr && (strb.kind != K_NONE);
  assign selF    = selQ;
  assign enF     = enQ;
  assign maskF   = maskQ;
  assign prioAll = prioQ;
  assign prioFlat = prioAll[PRIO_W*NSRC-1:0];

  // write-one-to-clear, limited to bits routed to the written register
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      clrB[b] = '0;
      if (doWr && strb.idx == SELIDX_W'(b)) begin
        if (strb.kind == K_IPEND) clrB[b] = wdata & ~selQ[b];
        if (strb.kind == K_FPEND) clrB[b] = wdata & selQ[b];
      end
    end
  end
  assign clrF  = clrB;
  assign pendD = (pendQ & ~clrF) | (src & enF);

  always_comb begin
    eligF    = pendQ & enF & ~maskF;
    eligF[0] = 1'b0;
  end
  assign eligIrq = eligF & ~selF;
  assign eligFiq = eligF & selF;
  assign irqOut  = |eligIrq;
  assign fiqOut  = |eligFiq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseQ <= '0;
      protQ <= '0;
      nmiQ  <= '0;
      selQ  <= '0;
      enQ   <= '0;
      maskQ <= '0;
      respQ <= '0;
      prioQ <= '0;
      pendQ <= '0;
    end else begin
      pendQ <= pendD;
      if (doWr) begin
        case (strb.kind)
          K_BASE: baseQ <= wdata;
          K_PROT: protQ <= wdata;
          K_NMI:  nmiQ  <= wdata;
          default: ;
        endcase
        for (int b = 0; b < BANKS; b++) begin
          if (strb.idx == SELIDX_W'(b)) begin
            case (strb.kind)
              K_SEL:  selQ[b]  <= wdata;
              K_EN:   enQ[b]   <= wdata;
              K_MASK: maskQ[b] <= wdata;
              K_RESP: respQ[b] <= wdata;
              default: ;
            endcase
          end
        end
        for (int p = 0; p < PRIO_REGS; p++) begin
          if (strb.kind == K_PRIO && strb.idx == SELIDX_W'(p)) prioQ[p] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (strb.kind)
      K_VEC:  rdNext = winValid ? DATA_W'({winIdx, 2'b00}) : '0;
      K_BASE: rdNext = baseQ;
      K_PROT: rdNext = protQ;
      K_NMI:  rdNext = nmiQ;
      default: ;
    endcase
    for (int b = 0; b < BANKS; b++) begin
      if (strb.idx == SELIDX_W'(b)) begin
        case (strb.kind)
          K_IPEND: rdNext = pendQ[BANK_W*b +: BANK_W] & ~selQ[b];
          K_FPEND: rdNext = pendQ[BANK_W*b +: BANK_W] & selQ[b];
          K_SEL:   rdNext = selQ[b];
          K_EN:    rdNext = enQ[b];
          K_MASK:  rdNext = maskQ[b];
          K_RESP:  rdNext = respQ[b];
          default: ;
        endcase
      end
    end
    for (int p = 0; p < PRIO_REGS; p++) begin
      if (strb.kind == K_PRIO && strb.idx == SELIDX_W'(p)) rdNext = prioQ[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (strb.rd) rdata <= rdNext;
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o,
  output logic              fiq_o
);
  busStrobe_t              strb;
  logic [NSRC-1:0]         eligIrq, eligFiq;
  logic [PRIO_W*NSRC-1:0]  prioFlat;
  logic                    winValid;
  logic [IDX_W-1:0]        winIdx;

  vec_intc_ctrl u_ctrl (
    .busAddr(bus_addr), .busWr(bus_wr), .busRd(bus_rd), .strb(strb)
  );

  vec_intc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(bus_wdata), .src(src_i),
    .winValid(winValid), .winIdx(winIdx), .rdata(bus_rdata),
    .eligIrq(eligIrq), .eligFiq(eligFiq), .prioFlat(prioFlat),
    .irqOut(irq_o), .fiqOut(fiq_o)
  );

  vec_intc_arb u_arb (
    .elig(eligIrq), .prioFlat(prioFlat), .winValid(winValid), .winIdx(winIdx)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vec_intc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              winValid,
  input logic [IDX_W-1:0]  winIdx,
  input logic [NSRC-1:0]   eligIrq
);
  AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> winValid); // R6
  AST_WINNER_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) winValid |-> irq_o); // R6
  AST_NO_SOURCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) winValid |-> (winIdx != '0)); // R6
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n) winValid |-> eligIrq[winIdx]); // R3
  AST_FIQ_NOT_VECTORED: assert property (@(posedge clk) disable iff (!rst_n) (fiq_o && !irq_o) |-> !winValid); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(bus_rd) |-> $stable(bus_rdata)); // R9
endmodule

bind vec_intc vec_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .fiq_o(fiq_o), .winValid(winValid), .winIdx(winIdx),
  .eligIrq(eligIrq)
);

// File: tb/sim_vec_intc.sv
`timescale 1ns/1ps
module sim_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [95:0] src_i = '0;
  logic        irq_o, fiq_o;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulseSrc(input int s);
    @(negedge clk);
    src_i[s] = 1'b1;
    @(negedge clk);
    src_i[s] = 1'b0;
  endtask

  function automatic logic [7:0] bankAddr(input logic [7:0] base, input int s);
    return base + 8'(4 * (s >> 5));
  endfunction

  function automatic logic [31:0] bitOf(input int s);
    return 32'h1 << (s & 31);
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    check("R10 irq_o", {31'b0, irq_o}, 0);
    check("R10 fiq_o", {31'b0, fiq_o}, 0);
    check("R10 rdata", bus_rdata, 0);
    regRead(8'h40, v); check("R10 enable0", v, 0);
    regRead(8'h54, v); check("R10 mask1", v, 0);
    regRead(8'h18, v); check("R10 pend2", v, 0);
    regRead(8'h00, v); check("R10 vector", v, 0);

    // R8: plain storage read-back
    regWrite(8'h04, 32'hA5A5_1234); regRead(8'h04, v); check("R8 base", v, 32'hA5A5_1234);
    regWrite(8'h08, 32'h1);         regRead(8'h08, v); check("R8 prot", v, 32'h1);
    regWrite(8'h0c, 32'h0000_00F0); regRead(8'h0c, v); check("R8 nmi", v, 32'h0000_00F0);
    regWrite(8'h68, 32'hDEAD_BEEF); regRead(8'h68, v); check("R8 resp2", v, 32'hDEAD_BEEF);
    regWrite(8'h94, 32'h0000_3C00); regRead(8'h94, v); check("R8 prio5", v, 32'h0000_3C00);
    regWrite(8'h94, 32'h0);

    // R9: undefined offsets, write ignored, read latency
    regWrite(8'h1c, 32'hFFFF_FFFF); regRead(8'h1c, v); check("R9 undef 0x1c", v, 0);
    regWrite(8'h70, 32'h1234_5678); regRead(8'h70, v); check("R9 undef 0x70", v, 0);
    regWrite(8'h98, 32'hFFFF_FFFF); regRead(8'h80, v); check("R9 write 0x98 no effect", v, 0);
    regWrite(8'h45, 32'hFFFF_FFFF); regRead(8'h40, v); check("R9 unaligned write ignored", v, 0);
    regRead(8'h04, v);
    @(negedge clk);
    check("R9 rdata holds without read", bus_rdata, 32'hA5A5_1234);
    @(negedge clk);
    bus_addr = 8'h0c; bus_rd = 1'b1;
    #1 check("R9 rdata before edge", bus_rdata, 32'hA5A5_1234);
    @(negedge clk); bus_rd = 1'b0;
    check("R9 rdata after edge", bus_rdata, 32'h0000_00F0);

    // R1/R6: walk every source through the vector
    for (int b = 0; b < 3; b++) regWrite(8'(8'h40 + 4 * b), 32'hFFFF_FFFF);
    for (int s = 1; s < 96; s++) begin
      pulseSrc(s);
      check("R1 irq after capture", {31'b0, irq_o}, 1);
      regRead(8'h00, v); check("R6 vector walk", v, 32'(s << 2));
      regRead(bankAddr(8'h10, s), v); check("R1 pending bit", v, bitOf(s));
      regWrite(bankAddr(8'h10, s), bitOf(s));
    end
    check("R2 all clear", {31'b0, irq_o}, 0);

    // R7: priority pairs across two priority words, source 17 vs source 70
    for (int pa = 0; pa < 4; pa++) begin
      for (int pb = 0; pb < 4; pb++) begin
        regWrite(8'h84, 32'(pa << 2));
        regWrite(8'h90, 32'(pb << 12));
        @(negedge clk); src_i[17] = 1'b1; src_i[70] = 1'b1;
        @(negedge clk); src_i[17] = 1'b0; src_i[70] = 1'b0;
        regRead(8'h00, v);
        check("R7 priority winner", v, (pb > pa) ? 32'(70 << 2) : 32'(17 << 2));
        regWrite(8'h10, bitOf(17));
        regWrite(8'h18, bitOf(70));
      end
    end
    regWrite(8'h84, 0); regWrite(8'h90, 0);
    // R7: tie within one bank goes to lower number
    @(negedge clk); src_i[9] = 1'b1; src_i[3] = 1'b1;
    @(negedge clk); src_i[9] = 1'b0; src_i[3] = 1'b0;
    regRead(8'h00, v); check("R7 tie lowest", v, 32'(3 << 2));
    regWrite(8'h80, 32'h3 << 18);
    regRead(8'h00, v); check("R7 raised field wins", v, 32'(9 << 2));
    regWrite(8'h80, 0); regWrite(8'h10, bitOf(9) | bitOf(3));

    // R3: mask gating
    pulseSrc(37);
    regWrite(8'h54, bitOf(37));
    check("R3 masked irq", {31'b0, irq_o}, 0);
    regRead(8'h00, v); check("R3 masked vector", v, 0);
    regRead(8'h14, v); check("R3 pending kept", v, bitOf(37));
    regWrite(8'h54, 0);
    check("R3 unmasked irq", {31'b0, irq_o}, 1);
    regWrite(8'h14, bitOf(37));

    // R4: enable gating
    regWrite(8'h40, ~bitOf(6));
    pulseSrc(6);
    regRead(8'h10, v); check("R4 no capture when disabled", v, 0);
    pulseSrc(7);
    regWrite(8'h40, ~bitOf(7));
    check("R4 disabled pending not delivered", {31'b0, irq_o}, 0);
    regRead(8'h00, v); check("R4 vector disabled", v, 0);
    regRead(8'h10, v); check("R4 pending retained", v, bitOf(7));
    regWrite(8'h40, 32'hFFFF_FFFF);
    check("R4 re-enable delivers", {31'b0, irq_o}, 1);

    // R2: write zero no effect, write one clears, held source re-pends
    regWrite(8'h10, 0);
    regRead(8'h10, v); check("R2 write zero keeps", v, bitOf(7));
    regWrite(8'h10, bitOf(7));
    regRead(8'h10, v); check("R2 write one clears", v, 0);
    @(negedge clk); src_i[12] = 1'b1;
    regWrite(8'h10, bitOf(12));
    regRead(8'h10, v); check("R2 held source re-pends", v, bitOf(12));
    src_i[12] = 1'b0;
    regWrite(8'h10, bitOf(12));
    regRead(8'h10, v); check("R2 cleared after release", v, 0);

    // R5: fast routing
    regWrite(8'h34, bitOf(40));
    regRead(8'h34, v); check("R8 select readback", v, bitOf(40));
    pulseSrc(40);
    check("R5 fiq raised", {31'b0, fiq_o}, 1);
    check("R5 irq quiet", {31'b0, irq_o}, 0);
    regRead(8'h24, v); check("R5 fast pending", v, bitOf(40));
    regRead(8'h14, v); check("R5 normal pending empty", v, 0);
    regRead(8'h00, v); check("R5 not vectored", v, 0);
    regWrite(8'h14, bitOf(40));
    regRead(8'h24, v); check("R5 wrong register no clear", v, bitOf(40));
    regWrite(8'h24, bitOf(40));
    check("R5 fiq cleared", {31'b0, fiq_o}, 0);
    regWrite(8'h34, 0);

    // R6: source 0 never delivered
    pulseSrc(0);
    check("R6 src0 irq", {31'b0, irq_o}, 0);
    check("R6 src0 fiq", {31'b0, fiq_o}, 0);
    regRead(8'h00, v); check("R6 src0 vector", v, 0);
    regRead(8'h10, held); check("R6 src0 pending visible", held, 32'h1);
    regWrite(8'h10, 32'h1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule